// File: doc/BRIEF.md
# Lane-Partitioned Packed Integer Adder

This block adds two 128-bit packed integer vectors lane by lane. A two-bit size code selects the lane width, and a separate short-vector bit selects the 64-bit vector form. The adder is a single 128-bit carry chain built from 8-bit segments. At every segment edge where a lane ends, the carry into the next segment is forced to zero, so each lane wraps modulo its own width. Lane 0 is in the least significant bits.

In the short form, lanes cover only bits 63:0 and result bits 127:64 are zero. The short form has no 64-bit-element arrangement. That combination raises an error flag and gives an all-zero result. The result, its valid flag and the error flag are registered and appear one cycle after the input strobe.

A small two-state controller (IDLE, HOLD) tracks whether the output register holds a fresh result. The transition IDLE->HOLD is taken on an accepted strobe. HOLD->HOLD is taken on back-to-back strobes. HOLD->IDLE is taken when no strobe arrives. The output valid is asserted exactly in HOLD.

Top module: `simd_lane_adder`

## Requirements
- R1: After reset the output valid, error flag and result are all zero.
- R2: The output valid is high in exactly the cycle after a cycle in which the input strobe was high, and low otherwise.
- R3: With size code 2'b00, each of the 8-bit lanes i (bits 8i+7:8i) holds (a_i + b_i) mod 2^8.
- R4: With size code 2'b01, each 16-bit lane holds the sum of its operand lanes modulo 2^16.
- R5: With size code 2'b10, each 32-bit lane holds the sum of its operand lanes modulo 2^32.
- R6: With size code 2'b11, each of the two 64-bit lanes holds the sum modulo 2^64.
- R7: No carry crosses a lane boundary. An all-ones lane plus one gives zero in that lane and leaves the next lane unchanged.
- R8: With the short bit high and a size code below 2'b11, bits 63:0 follow R3 to R5 and bits 127:64 of the result are zero.
- R9: With the short bit high and size code 2'b11, the error flag is high and the result is all zero. Otherwise the error flag is low.
- R10: When the strobe is low, the result and error flag hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operand strobe |
| elem_sz | input | 2 | Lane width code: 00=8, 01=16, 10=32, 11=64 bits |
| short_vec | input | 1 | High selects the 64-bit vector form |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_err | output | 1 | Illegal short-form/64-bit combination |
| out_sum | output | 128 | Lane-wise sum |

## Verification
A wrong carry-gate decode shows up as a single lane that is off by one. A carry leaks into its neighbour when the lower lane wraps. Such a fault appears in out_sum in the cycle after the offending strobe. A controller stuck in IDLE or HOLD shows as out_vld missing or lingering in the cycle right after a strobe edge. A wrong short-form decode shows as non-zero upper bits or a missing error flag on the very next result.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;
    localparam int VEC_W  = 128;
    localparam int SEG_W  = 8;
    localparam int NSEG   = VEC_W / SEG_W;
    localparam int HALF_W = VEC_W / 2;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } elem_sz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/lane_carry_gate.sv
module lane_carry_gate
    import simd_lane_pkg::*;
#(
    parameter int NS = NSEG
) (
    input  logic [1:0]    sz,
    output logic [NS-1:0] pass_c
);
    // pass_c[k]: carry from segment k-1 may enter segment k
    for (genvar k = 0; k < NS; k++) begin : g_gate
        if (k == 0) begin : g_lsb
            assign pass_c[k] = 1'b0;
        end else begin : g_mid
            always_comb begin
                unique case (elem_sz_e'(sz))
                    SZ_8:  pass_c[k] = 1'b0;
                    SZ_16: pass_c[k] = (k % 2) != 0;
                    SZ_32: pass_c[k] = (k % 4) != 0;
                    SZ_64: pass_c[k] = (k % 8) != 0;
                    default: pass_c[k] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/seg_chain_adder.sv
module seg_chain_adder
    import simd_lane_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int SW = SEG_W
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [W/SW-1:0] pass_c,
    output logic [W-1:0]    s
);
    localparam int NS = W / SW;
    logic [NS:0] cy;
    assign cy[0] = 1'b0;

    for (genvar k = 0; k < NS; k++) begin : g_seg
        logic        cin;
        logic [SW:0] wide;
        assign cin  = cy[k] & pass_c[k];
        assign wide = {1'b0, a[k*SW +: SW]} + {1'b0, b[k*SW +: SW]} + {{SW{1'b0}}, cin};
        assign s[k*SW +: SW] = wide[SW-1:0];
        assign cy[k+1] = wide[SW];
    end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_lane_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [1:0]    elem_sz,
    input  logic          short_vec,
    input  logic [127:0]  opa,
    input  logic [127:0]  opb,
    output logic          out_vld,
    output logic          out_err,
    output logic [127:0]  out_sum
);
    logic [NSEG-1:0]  pass_c;
    logic [VEC_W-1:0] raw_sum;
    logic [VEC_W-1:0] nxt_sum;
    logic             nxt_err;
    ctl_state_e       st_q, st_d;

    lane_carry_gate #(.NS(NSEG)) u_gate (
        .sz     (elem_sz),
        .pass_c (pass_c)
    );

    seg_chain_adder #(.W(VEC_W), .SW(SEG_W)) u_add (
        .a      (opa),
        .b      (opb),
        .pass_c (pass_c),
        .s      (raw_sum)
    );

    always_comb begin
        nxt_err = short_vec && (elem_sz == SZ_64);
        if (nxt_err)
            nxt_sum = '0;
        else if (short_vec)
            nxt_sum = {{HALF_W{1'b0}}, raw_sum[HALF_W-1:0]};
        else
            nxt_sum = raw_sum;
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = in_vld ? ST_HOLD : ST_IDLE;
            ST_HOLD: st_d = in_vld ? ST_HOLD : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sum <= '0;
            out_err <= 1'b0;
        end else if (in_vld) begin
            out_sum <= nxt_sum;
            out_err <= nxt_err;
        end
    end

    assign out_vld = (st_q == ST_HOLD);
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_vld,
    input logic [1:0]   elem_sz,
    input logic         short_vec,
    input logic [127:0] out_sum,
    input logic         out_vld,
    input logic         out_err
);
    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld); // R2
    AST_VLD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld); // R2
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && short_vec && elem_sz == 2'b11) |=> (out_err && out_sum == '0)); // R9
    AST_NO_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !(short_vec && elem_sz == 2'b11)) |=> !out_err); // R9
    AST_SHORT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && short_vec) |=> (out_sum[127:64] == '0)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && $past(rst_n)) |=> ($stable(out_sum) && $stable(out_err))); // R10
endmodule

bind simd_lane_adder simd_lane_adder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .elem_sz   (elem_sz),
    .short_vec (short_vec),
    .out_sum   (out_sum),
    .out_vld   (out_vld),
    .out_err   (out_err)
);

// File: tb/simd_lane_adder_test.sv
module simd_lane_adder_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic [1:0]   elem_sz = 2'b00;
    logic         short_vec = 1'b0;
    logic [127:0] opa = '0, opb = '0;
    logic         out_vld, out_err;
    logic [127:0] out_sum;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_lane_adder uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .elem_sz(elem_sz),
        .short_vec(short_vec), .opa(opa), .opb(opb),
        .out_vld(out_vld), .out_err(out_err), .out_sum(out_sum)
    );

    function automatic logic [127:0] ref_sum(input logic [127:0] a, input logic [127:0] b,
                                             input logic [1:0] sz, input logic sh);
        logic [127:0] r;
        int w;
        r = '0;
        w = 8 << sz;
        if (sh && sz == 2'b11) return '0;
        for (int i = 0; i < 128 / w; i++) begin
            logic [127:0] m, la, lb;
            m  = ({128{1'b1}} >> (128 - w)) << (i * w);
            la = (a & m) >> (i * w);
            lb = (b & m) >> (i * w);
            r  = r | (((la + lb) << (i * w)) & m);
        end
        if (sh) r[127:64] = '0;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(input string tag, input logic [127:0] a, input logic [127:0] b,
                           input logic [1:0] sz, input logic sh);
        @(negedge clk);
        opa = a; opb = b; elem_sz = sz; short_vec = sh; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        chk({tag, " R2 vld"}, {127'd0, out_vld}, 128'd1);
        chk({tag, " sum"}, out_sum, ref_sum(a, b, sz, sh));
        chk({tag, " R9 err"}, {127'd0, out_err}, {127'd0, sh && sz == 2'b11});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vld", {127'd0, out_vld}, 128'd0);
        chk("R1 err", {127'd0, out_err}, 128'd0);
        chk("R1 sum", out_sum, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 no strobe", {127'd0, out_vld}, 128'd0);

        // R7 lane edges: all-ones plus one in lane 0
        run_one("R3 R7 b8",  {128{1'b1}}, 128'h1, 2'b00, 1'b0);
        run_one("R4 R7 h16", {128{1'b1}}, 128'h1, 2'b01, 1'b0);
        run_one("R5 R7 s32", {128{1'b1}}, 128'h1, 2'b10, 1'b0);
        run_one("R6 R7 d64", {128{1'b1}}, 128'h1, 2'b11, 1'b0);
        run_one("R7 lane1", 128'h0000_ffff, 128'h0000_0001, 2'b01, 1'b0);
        chk("R7 direct", out_sum, 128'h0000_0000);
        run_one("R8 short", {128{1'b1}}, {128{1'b1}}, 2'b10, 1'b1);
        run_one("R9 illegal", {128{1'b1}}, 128'h5, 2'b11, 1'b1);

        // R10 hold: strobe low, change inputs
        held = out_sum;
        @(negedge clk);
        opa = '1; opb = '1; elem_sz = 2'b00; short_vec = 1'b0;
        @(negedge clk);
        chk("R10 hold sum", out_sum, held);
        chk("R10 hold err", {127'd0, out_err}, 128'd1);
        chk("R2 vld low", {127'd0, out_vld}, 128'd0);

        for (int n = 0; n < 400; n++) begin
            logic [127:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            if (n % 3 == 0) b = ~a;
            run_one("R3 R4 R5 R6 R8 rand", a, b, 2'($urandom), 1'($urandom));
        end

        // R2 back-to-back strobes
        @(negedge clk);
        opa = 128'h1; opb = 128'h2; elem_sz = 2'b00; short_vec = 1'b0; in_vld = 1'b1;
        @(negedge clk);
        opa = 128'h3;
        @(negedge clk);
        in_vld = 1'b0;
        chk("R2 b2b vld", {127'd0, out_vld}, 128'd1);
        chk("R3 b2b sum", out_sum, 128'h5);
        @(negedge clk);
        chk("R2 b2b end", {127'd0, out_vld}, 128'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule